// File: doc/BRIEF.md
# Profile Linear Detrend Unit

This block takes one intensity profile of a fixed number of pixels, for example a line of gray levels cut across interference fringes, and removes the straight line that best fits it in the least-squares sense. Samples arrive one per cycle on a valid/ready stream and are held in an internal buffer. The block then reads the buffer again to build the covariance of intensity against pixel position. Two divisions on one shared restoring shift-subtract divider give the mean intensity and the slope, and the intercept is derived from them. A final pass plays the buffered samples back with the fitted line subtracted.

Results are signed fixed point with `FRAC` fractional bits. During playback the block tracks the smallest and largest corrected sample. One cycle after the last corrected sample it raises a single-cycle completion strobe. With that strobe it presents half the peak-to-peak span as the amplitude, together with the fitted slope and intercept. The input stays blocked from the moment the last sample is taken until that strobe, so the block holds exactly one profile at a time.

Pixel positions are handled as the doubled centred index `d(i) = 2i - (NPIX-1)`, which keeps the mean position (NPIX-1)/2 exact. Because the `d(i)` sum to zero, the covariance sum of `d(i)*(I[i] - mean)` equals the sum of `d(i)*I[i]`. The variance sum of `d(i)^2` is the constant `V = NPIX*(NPIX^2-1)/3`.

Top module: `prof_detrend`

## Requirements
- R1: While reset is held and in the first cycle after it is released, `in_ready` is 1, `out_valid` is 0 and `done` is 0.
- R2: While `in_ready` is 1, each cycle with `in_valid` high stores `in_data` as the next pixel. After the NPIX-th pixel is taken, `in_ready` is 0 until the cycle after `done`. Any `in_valid`/`in_data` driven while `in_ready` is 0 is ignored and has no effect on any result.
- R3: The mean intensity is `mean = floor(S * 2^FRAC / NPIX)`, where S is the sum of the NPIX unsigned samples.
- R4: The fitted slope, with FRAC fractional bits, is `sign(C) * floor(2*|C| * 2^FRAC / V)`. Here `C = sum d(i)*I[i]`, so the quotient is truncated toward zero. `fit_slope` carries this value while `done` is high.
- R5: The intercept is `fit_icpt = mean - floor(slope*(NPIX-1)/2)`, using an arithmetic right shift by one. It is valid while `done` is high.
- R6: Playback presents NPIX consecutive cycles with `out_valid` high. In cycle k it carries `out_data = I[k]*2^FRAC - fit_icpt - slope*k`, for k = 0..NPIX-1 in index order.
- R7: `amp = floor((max - min)/2)` over the NPIX values of `out_data` in that playback. It is valid while `done` is high.
- R8: `done` is high for exactly one cycle, the cycle right after the last playback sample, and `in_ready` returns to 1 in the cycle after it.
- R9: With the default parameters (NPIX=20, W=8, FRAC=8), `done` rises no more than 128 cycles after the last pixel is accepted. That is far below the 1562 cycles that a 12.5 µs budget allows at 125 MHz.
- R10: An exact integer ramp `I[i] = a + b*i` yields `out_data` = 0 for every pixel. A ramp carrying a sinusoid of amplitude 40 gives `amp` within 12*2^FRAC of 40*2^FRAC.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Input sample present |
| in_data | input | W | Unsigned pixel intensity |
| in_ready | output | 1 | Block accepts a sample this cycle |
| out_valid | output | 1 | Corrected sample present |
| out_data | output | W+FRAC+4 | Signed corrected sample, FRAC fractional bits |
| done | output | 1 | One-cycle completion strobe |
| amp | output | W+FRAC+4 | Half peak-to-peak of the corrected samples |
| fit_slope | output | W+FRAC+4 | Signed fitted slope per pixel |
| fit_icpt | output | W+FRAC+4 | Signed fitted intercept |

## Verification
The bench sweeps ramps of slope -6 to +6 with noise added, and runs random profiles, flat profiles at 0 and at full scale, and single-pixel spikes at either end. The spikes catch a covariance built with a wrong index sign or offset, which would tilt the line the wrong way and break every residual. Descending ramps produce a negative covariance, where a divider that rounded toward minus infinity, or that lost the sign, would be off by one LSB or change sign. Junk held on the input while the block is busy would corrupt the buffer if it were not ignored. Latency and strobe placement are checked cycle by cycle, so a divider that runs one step too long or too short shows up as shifted quotient bits.

// File: rtl/prof_pkg.sv
package prof_pkg;

    typedef enum logic [2:0] {
        ST_LOAD,
        ST_COV,
        ST_DMEAN,
        ST_DSLOPE,
        ST_ICPT,
        ST_REPLAY,
        ST_FIN
    } prof_state_e;

    function automatic int unsigned centred_var(input int unsigned n);
        return n * (n * n - 1) / 3;
    endfunction

endpackage

// File: rtl/prof_buffer.sv
module prof_buffer #(
    parameter int W    = 8,
    parameter int NPIX = 20
) (
    input  logic                      clk,
    input  logic                      wr_en,
    input  logic [$clog2(NPIX)-1:0]   wr_addr,
    input  logic [W-1:0]              wr_data,
    input  logic [$clog2(NPIX)-1:0]   rd_addr,
    output logic [W-1:0]              rd_data
);
    localparam int IDXW = $clog2(NPIX);

    logic [W-1:0] cell_q [NPIX];

    for (genvar g = 0; g < NPIX; g++) begin : g_cell
        always_ff @(posedge clk) begin
            if (wr_en && wr_addr == IDXW'(g)) begin
                cell_q[g] <= wr_data;
            end
        end
    end

    always_comb begin
        rd_data = '0;
        for (int k = 0; k < NPIX; k++) begin
            if (rd_addr == IDXW'(k)) begin
                rd_data = cell_q[k];
            end
        end
    end

endmodule

// File: rtl/prof_divider.sv
module prof_divider #(
    parameter int NUMW = 29
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            go,
    input  logic [NUMW-1:0] num,
    input  logic [NUMW-1:0] den,
    output logic            done,
    output logic [NUMW-1:0] quo
);
    localparam int CNTW = $clog2(NUMW + 1);

    typedef struct packed {
        logic [NUMW-1:0] rq;
        logic [NUMW-1:0] rem;
        logic [NUMW-1:0] den;
        logic [CNTW-1:0] cnt;
        logic            busy;
        logic            fin;
    } dv_t;

    dv_t             dv_d, dv_q;
    logic [NUMW:0]   trial;
    logic            qbit;

    always_comb begin
        dv_d     = dv_q;
        dv_d.fin = 1'b0;
        trial    = {dv_q.rem, dv_q.rq[NUMW-1]};
        qbit     = 1'b0;
        if (go) begin
            dv_d.rq   = num;
            dv_d.rem  = '0;
            dv_d.den  = den;
            dv_d.cnt  = CNTW'(NUMW);
            dv_d.busy = 1'b1;
        end else if (dv_q.busy) begin
            if (trial >= {1'b0, dv_q.den}) begin
                dv_d.rem = NUMW'(trial - {1'b0, dv_q.den});
                qbit     = 1'b1;
            end else begin
                dv_d.rem = NUMW'(trial);
            end
            dv_d.rq  = {dv_q.rq[NUMW-2:0], qbit};
            dv_d.cnt = dv_q.cnt - CNTW'(1);
            if (dv_q.cnt == CNTW'(1)) begin
                dv_d.busy = 1'b0;
                dv_d.fin  = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dv_q <= '0;
        end else begin
            dv_q <= dv_d;
        end
    end

    assign done = dv_q.fin;
    assign quo  = dv_q.rq;

    // R4: the divider is never restarted mid-division
    assert_no_restart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dv_q.busy |-> !go);

    // R4: a finished division leaves a remainder below the divisor
    assert_rem_below_den_R4: assert property (@(posedge clk) disable iff (!rst_n)
        dv_q.fin |-> (dv_q.rem < dv_q.den));

endmodule

// File: rtl/prof_detrend.sv
module prof_detrend
    import prof_pkg::*;
#(
    parameter int NPIX = 20,
    parameter int W    = 8,
    parameter int FRAC = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [W-1:0]            in_data,
    output logic                    in_ready,
    output logic                    out_valid,
    output logic signed [W+FRAC+3:0] out_data,
    output logic                    done,
    output logic signed [W+FRAC+3:0] amp,
    output logic signed [W+FRAC+3:0] fit_slope,
    output logic signed [W+FRAC+3:0] fit_icpt
);
    localparam int IDXW = $clog2(NPIX);
    localparam int SW   = W + IDXW;
    localparam int CW   = W + 2 * IDXW + 2;
    localparam int NUMW = CW + FRAC + 1;
    localparam int SLW  = NUMW + 1;
    localparam int XW   = SLW + IDXW + W + 2;
    localparam int OW   = W + FRAC + 4;
    localparam int unsigned VAR4 = centred_var(NPIX);
    localparam logic [IDXW-1:0] LAST = IDXW'(NPIX - 1);

    typedef struct packed {
        prof_state_e              st;
        logic [IDXW-1:0]          idx;
        logic [SW-1:0]            sum;
        logic signed [CW-1:0]     cov;
        logic [NUMW-1:0]          mean;
        logic signed [SLW-1:0]    slope;
        logic signed [XW-1:0]     icpt;
        logic signed [OW-1:0]     vmax;
        logic signed [OW-1:0]     vmin;
    } regs_t;

    regs_t r_d, r_q;

    logic                  wr_en;
    logic [W-1:0]          rd_data;
    logic                  div_go;
    logic [NUMW-1:0]       div_num;
    logic [NUMW-1:0]       div_den;
    logic                  div_done;
    logic [NUMW-1:0]       div_quo;

    logic signed [XW-1:0]  idx_x;
    logic signed [XW-1:0]  d_x;
    logic signed [XW-1:0]  smp_x;
    logic signed [XW-1:0]  slope_x;
    logic signed [XW-1:0]  mean_x;
    logic signed [CW-1:0]  cov_abs;
    logic signed [OW-1:0]  res_o;

    prof_buffer #(.W(W), .NPIX(NPIX)) i_buf (
        .clk     (clk),
        .wr_en   (wr_en),
        .wr_addr (r_q.idx),
        .wr_data (in_data),
        .rd_addr (r_q.idx),
        .rd_data (rd_data)
    );

    prof_divider #(.NUMW(NUMW)) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .go    (div_go),
        .num   (div_num),
        .den   (div_den),
        .done  (div_done),
        .quo   (div_quo)
    );

    always_comb begin
        idx_x   = XW'($signed({1'b0, r_q.idx}));
        d_x     = (idx_x <<< 1) - XW'(NPIX - 1);
        smp_x   = XW'($signed({1'b0, rd_data}));
        slope_x = XW'(r_q.slope);
        mean_x  = XW'($signed({1'b0, r_q.mean}));
        cov_abs = (r_q.cov < 0) ? -r_q.cov : r_q.cov;
        res_o   = OW'((smp_x <<< FRAC) - r_q.icpt - slope_x * idx_x);
    end

    always_comb begin
        r_d     = r_q;
        wr_en   = 1'b0;
        div_go  = 1'b0;
        div_num = '0;
        div_den = '0;
        case (r_q.st)
            ST_LOAD: begin
                if (in_valid) begin
                    wr_en    = 1'b1;
                    r_d.sum  = r_q.sum + SW'(in_data);
                    if (r_q.idx == LAST) begin
                        r_d.idx = '0;
                        r_d.st  = ST_COV;
                    end else begin
                        r_d.idx = r_q.idx + IDXW'(1);
                    end
                end
            end
            ST_COV: begin
                r_d.cov = r_q.cov + CW'(d_x * smp_x);
                if (r_q.idx == LAST) begin
                    r_d.idx = '0;
                    div_go  = 1'b1;
                    div_num = NUMW'({r_q.sum, {FRAC{1'b0}}});
                    div_den = NUMW'(NPIX);
                    r_d.st  = ST_DMEAN;
                end else begin
                    r_d.idx = r_q.idx + IDXW'(1);
                end
            end
            ST_DMEAN: begin
                if (div_done) begin
                    r_d.mean = div_quo;
                    div_go   = 1'b1;
                    div_num  = {cov_abs, {(FRAC + 1){1'b0}}};
                    div_den  = NUMW'(VAR4);
                    r_d.st   = ST_DSLOPE;
                end
            end
            ST_DSLOPE: begin
                if (div_done) begin
                    r_d.slope = (r_q.cov < 0) ? -$signed({1'b0, div_quo})
                                              :  $signed({1'b0, div_quo});
                    r_d.st    = ST_ICPT;
                end
            end
            ST_ICPT: begin
                r_d.icpt = mean_x - ((slope_x * XW'(NPIX - 1)) >>> 1);
                r_d.idx  = '0;
                r_d.st   = ST_REPLAY;
            end
            ST_REPLAY: begin
                if (r_q.idx == '0 || res_o > r_q.vmax) r_d.vmax = res_o;
                if (r_q.idx == '0 || res_o < r_q.vmin) r_d.vmin = res_o;
                if (r_q.idx == LAST) begin
                    r_d.idx = '0;
                    r_d.st  = ST_FIN;
                end else begin
                    r_d.idx = r_q.idx + IDXW'(1);
                end
            end
            ST_FIN: begin
                r_d.st  = ST_LOAD;
                r_d.sum = '0;
                r_d.cov = '0;
                r_d.idx = '0;
            end
            default: r_d.st = ST_LOAD;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q    <= '0;
            r_q.st <= ST_LOAD;
        end else begin
            r_q <= r_d;
        end
    end

    assign in_ready  = (r_q.st == ST_LOAD);
    assign out_valid = (r_q.st == ST_REPLAY);
    assign out_data  = out_valid ? res_o : '0;
    assign done      = (r_q.st == ST_FIN);
    assign amp       = OW'(((OW + 1)'(r_q.vmax) - (OW + 1)'(r_q.vmin)) >>> 1);
    assign fit_slope = OW'(r_q.slope);
    assign fit_icpt  = OW'(r_q.icpt);

    // R2: taking the last pixel closes the input
    assert_ready_drops_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready && r_q.idx == LAST) |=> !in_ready);

    // R6: playback walks the index one step per cycle
    assert_index_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(out_valid)) |-> (r_q.idx == $past(r_q.idx) + IDXW'(1)));

    // R7: the running extremes stay ordered during playback
    assert_extremes_ordered_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && r_q.idx != '0) |-> (r_q.vmax >= r_q.vmin));

    // R8: the strobe follows the last playback sample
    assert_done_after_last_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && r_q.idx == LAST) |=> done);

    // R8: the input reopens right after the strobe
    assert_done_then_ready_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> (in_ready && !done));

endmodule

// File: tb/test_prof_detrend.sv
module test_prof_detrend;

    localparam int NPIX = 20;
    localparam int W    = 8;
    localparam int FRAC = 8;
    localparam int OW   = W + FRAC + 4;
    localparam longint VAR4 = NPIX * (NPIX * NPIX - 1) / 3;
    localparam longint ONE  = 1 << FRAC;

    logic                   clk = 1'b0;
    logic                   rst_n = 1'b0;
    logic                   in_valid = 1'b0;
    logic [W-1:0]           in_data = '0;
    logic                   in_ready;
    logic                   out_valid;
    logic signed [OW-1:0]   out_data;
    logic                   done;
    logic signed [OW-1:0]   amp;
    logic signed [OW-1:0]   fit_slope;
    logic signed [OW-1:0]   fit_icpt;

    int total = 0;
    int bad   = 0;

    longint e_res [NPIX];
    longint e_slope, e_icpt, e_amp;
    longint g_res [NPIX];
    longint g_slope, g_icpt, g_amp;

    always #4 clk = ~clk;

    prof_detrend #(.NPIX(NPIX), .W(W), .FRAC(FRAC)) i_prof_detrend (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_data   (in_data),
        .in_ready  (in_ready),
        .out_valid (out_valid),
        .out_data  (out_data),
        .done      (done),
        .amp       (amp),
        .fit_slope (fit_slope),
        .fit_icpt  (fit_icpt)
    );

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic model(input int px [NPIX]);
        longint s = 0, c = 0, mean, mag, sl, ic, mx, mn;
        for (int i = 0; i < NPIX; i++) begin
            s += px[i];
            c += (2 * i - (NPIX - 1)) * px[i];
        end
        mean = (s * ONE) / NPIX;
        mag  = (c < 0) ? -c : c;
        sl   = (2 * mag * ONE) / VAR4;
        if (c < 0) sl = -sl;
        ic   = mean - ((sl * (NPIX - 1)) >>> 1);
        for (int i = 0; i < NPIX; i++) begin
            e_res[i] = px[i] * ONE - ic - sl * i;
            if (i == 0 || e_res[i] > mx) mx = e_res[i];
            if (i == 0 || e_res[i] < mn) mn = e_res[i];
        end
        e_slope = sl;
        e_icpt  = ic;
        e_amp   = (mx - mn) >>> 1;
    endtask

    task automatic run_profile(input int px [NPIX], input bit junk);
        int  cyc = 0, n = 0, last_out = -1, done_cyc = -1;
        bit  ready_leak = 0;
        model(px);
        for (int i = 0; i < NPIX; i++) begin
            @(negedge clk);
            if (i == 0) chk(in_ready == 1'b1, "R2 ready before load", longint'(in_ready), 1);
            in_valid = 1'b1;
            in_data  = W'(px[i]);
        end
        @(negedge clk);
        in_valid = junk;
        in_data  = 8'hA5;
        while (done_cyc < 0 && cyc < 300) begin
            if (in_ready) ready_leak = 1;
            if (out_valid) begin
                if (n < NPIX) g_res[n] = longint'(out_data);
                n++;
                last_out = cyc;
            end
            if (done) begin
                done_cyc = cyc;
                g_amp    = longint'(amp);
                g_slope  = longint'(fit_slope);
                g_icpt   = longint'(fit_icpt);
            end else begin
                @(negedge clk);
                cyc++;
            end
        end
        in_valid = 1'b0;
        chk(done_cyc >= 0 && done_cyc <= 128, "R9 latency", longint'(done_cyc), 128);
        chk(!ready_leak, "R2 ready low while busy (junk ignored)", longint'(ready_leak), 0);
        chk(n == NPIX, "R6 sample count", longint'(n), NPIX);
        chk(done_cyc == last_out + 1, "R8 done after last sample", longint'(done_cyc), longint'(last_out + 1));
        for (int i = 0; i < NPIX; i++) begin
            chk(g_res[i] == e_res[i], "R6 residual", g_res[i], e_res[i]);
        end
        chk(g_slope == e_slope, "R4 slope", g_slope, e_slope);
        chk(g_icpt == e_icpt, "R3 R5 intercept", g_icpt, e_icpt);
        chk(g_amp == e_amp, "R7 amplitude", g_amp, e_amp);
        @(negedge clk);
        chk(in_ready == 1'b1 && done == 1'b0, "R8 ready after done", longint'(in_ready), 1);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        total++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int px [NPIX];
        repeat (3) @(negedge clk);
        chk(in_ready == 1'b1 && out_valid == 1'b0 && done == 1'b0, "R1 reset state",
            longint'({in_ready, out_valid, done}), 4);
        rst_n = 1'b1;
        @(negedge clk);
        chk(in_ready == 1'b1 && out_valid == 1'b0 && done == 1'b0, "R1 after release",
            longint'({in_ready, out_valid, done}), 4);

        // R10: exact rising ramp leaves no residual
        for (int i = 0; i < NPIX; i++) px[i] = 10 + 3 * i;
        run_profile(px, 1'b1);
        for (int i = 0; i < NPIX; i++) chk(g_res[i] == 0, "R10 rising ramp removed", g_res[i], 0);

        // R10: exact falling ramp, negative covariance
        for (int i = 0; i < NPIX; i++) px[i] = 250 - 7 * i;
        run_profile(px, 1'b1);
        for (int i = 0; i < NPIX; i++) chk(g_res[i] == 0, "R10 falling ramp removed", g_res[i], 0);

        // R3: a flat profile gives its level as the intercept
        for (int i = 0; i < NPIX; i++) px[i] = 77;
        run_profile(px, 1'b0);
        chk(g_icpt == 77 * ONE, "R3 flat mean", g_icpt, 77 * ONE);

        for (int i = 0; i < NPIX; i++) px[i] = 0;
        run_profile(px, 1'b1);
        for (int i = 0; i < NPIX; i++) px[i] = 255;
        run_profile(px, 1'b1);

        // spikes at either end
        for (int i = 0; i < NPIX; i++) px[i] = (i == 0) ? 255 : 0;
        run_profile(px, 1'b1);
        for (int i = 0; i < NPIX; i++) px[i] = (i == NPIX - 1) ? 255 : 0;
        run_profile(px, 1'b0);

        // R10: ramp plus sinusoid, amplitude within tolerance
        for (int i = 0; i < NPIX; i++) px[i] = 100 + 2 * i + int'(40.0 * $cos(3.14159265358979 * i / 2.0));
        run_profile(px, 1'b1);
        chk(g_amp >= 28 * ONE && g_amp <= 52 * ONE, "R10 sinusoid amplitude", g_amp, 40 * ONE);

        // slope sweep with noise
        for (int s = -6; s <= 6; s++) begin
            for (int i = 0; i < NPIX; i++) px[i] = 128 - 10 * s + s * i + int'($urandom % 16);
            run_profile(px, s[0]);
        end

        // random profiles
        for (int k = 0; k < 8; k++) begin
            for (int i = 0; i < NPIX; i++) px[i] = int'($urandom % 256);
            run_profile(px, k[0]);
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule